// File: doc/BRIEF.md
# Display DMA Memory Window Decoder

This block steers display DMA read addresses to the right memory target. It holds a small set of programmable address windows. Each window has a size, a base and an optional remap value, plus the target ID and attribute byte that a downstream fabric needs for routing. Software fills the windows through a narrow register write port. The port names a window, picks one of its three words (control, base or remap) and carries the 32-bit data.

On the lookup side, a request address is presented with a valid strobe. One clock later the block reports the outcome. On a hit it gives the window index, target ID, attribute byte and the translated address. On a miss it raises a miss flag and drives all routing fields to zero. Windows may overlap, and the lowest-numbered matching window takes the request. Every address field works at 64 KB granularity.

Top module: `memwin_decoder`

## Requirements
- R1: After reset every window is disabled with all fields zero. rsp_valid, rsp_hit and rsp_miss are low, and any lookup misses until a window is enabled.
- R2: The response to a request presented with req_valid high at clock edge n appears after edge n. rsp_valid is high for exactly that one cycle and low in cycles that follow an idle request slot. When rsp_valid is low, rsp_hit and rsp_miss are both low.
- R3: Control word layout is as follows. Bits 31:16 are the size-minus-one mask in 64 KB units, bits 15:8 are the attribute, bits 7:4 are the target ID, and bit 0 is the enable. Bits 3:1 have no effect.
- R4: Only bits 31:16 of the base word are kept. The low 16 bits have no effect on matching.
- R5: An enabled window matches when (req_addr[31:16] & ~size_mask) equals the stored base bits.
- R6: A window whose enable bit is clear never matches, whatever its other fields hold.
- R7: When several windows match, the lowest window index wins. That window supplies rsp_win, rsp_target and rsp_attr.
- R8: On a hit with a zero remap value, rsp_addr equals req_addr. With a nonzero remap (bits 31:16 kept), rsp_addr[31:16] = (req_addr[31:16] & size_mask) | (remap & ~size_mask), and rsp_addr[15:0] = req_addr[15:0].
- R9: On a miss rsp_miss is 1 and rsp_hit is 0. rsp_win, rsp_target, rsp_attr and rsp_addr are all zero.
- R10: Write select codes are 0 for control, 1 for base and 2 for remap. Code 3 is ignored, as is any window index of NUM_WIN or above. A write in edge n affects lookups sampled from edge n+1 on. A lookup in the same edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | IDX_W | Window index for the write |
| cfg_sel | input | 2 | Word select: 0 control, 1 base, 2 remap |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Lookup address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Request matched no window |
| rsp_win | output | IDX_W | Index of the winning window |
| rsp_target | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The bench overlaps a large window with a smaller, higher-numbered one. A decoder with reversed priority would then report the wrong index and routing fields. It programs a remap whose bits fall inside the size mask, which a design that copies the whole remap value would wrongly pass into the output. It writes a base with low bits set, writes select code 3, and writes out-of-range window indices. A design that kept those bits or decoded those writes would then hit or miss where it should not. A write issued in the same cycle as a lookup checks that the lookup still uses the old window contents. Clearing only the enable bit checks that the other fields alone cannot produce a hit.

// File: rtl/memwin_decoder.sv
module memwin_decoder #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_win,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [IDX_W-1:0] rsp_win,
  output logic [3:0]       rsp_target,
  output logic [7:0]       rsp_attr,
  output logic [31:0]      rsp_addr
);

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BASE  = 2'd1;
  localparam logic [1:0] SEL_REMAP = 2'd2;

  logic [15:0]        size_q  [NUM_WIN];
  logic [15:0]        base_q  [NUM_WIN];
  logic [15:0]        remap_q [NUM_WIN];
  logic [7:0]         attr_q  [NUM_WIN];
  logic [3:0]         tgt_q   [NUM_WIN];
  logic [NUM_WIN-1:0] en_q;
  logic [NUM_WIN-1:0] match;

  wire [15:0] addr_hi = req_addr[31:16];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    wire sel_me = cfg_we && (cfg_win == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        size_q[w]  <= '0;
        base_q[w]  <= '0;
        remap_q[w] <= '0;
        attr_q[w]  <= '0;
        tgt_q[w]   <= '0;
        en_q[w]    <= 1'b0;
      end else if (sel_me) begin
        case (cfg_sel)
          SEL_CTRL: begin
            size_q[w] <= cfg_wdata[31:16];
            attr_q[w] <= cfg_wdata[15:8];
            tgt_q[w]  <= cfg_wdata[7:4];
            en_q[w]   <= cfg_wdata[0];
          end
          SEL_BASE:  base_q[w]  <= cfg_wdata[31:16];
          SEL_REMAP: remap_q[w] <= cfg_wdata[31:16];
          default: ;
        endcase
      end
    end

    assign match[w] = en_q[w] && ((addr_hi & ~size_q[w]) == base_q[w]);
  end

  logic             hit_c;
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    hit_c = 1'b0;
    idx_c = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_c = 1'b1;
        idx_c = IDX_W'(i);
      end
    end
  end

  wire [15:0] m_sel  = size_q[idx_c];
  wire [15:0] r_sel  = remap_q[idx_c];
  wire [15:0] out_hi = (r_sel != 16'h0) ? ((addr_hi & m_sel) | (r_sel & ~m_sel)) : addr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit_c;
      rsp_miss  <= req_valid && !hit_c;
      if (req_valid && hit_c) begin
        rsp_win    <= idx_c;
        rsp_target <= tgt_q[idx_c];
        rsp_attr   <= attr_q[idx_c];
        rsp_addr   <= {out_hi, req_addr[15:0]};
      end else begin
        rsp_win    <= '0;
        rsp_target <= '0;
        rsp_attr   <= '0;
        rsp_addr   <= '0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss)); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_win == '0 && rsp_target == '0 && rsp_attr == '0 && rsp_addr == '0)); // R9
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_addr[15:0] == $past(req_addr[15:0]))); // R8

endmodule

// File: tb/memwin_decoder_tb.sv
module memwin_decoder_tb_top;
  localparam int CLK_NS = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  always #(CLK_NS/2) clk = ~clk;

  memwin_decoder #(.NUM_WIN(NW), .IDX_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
    .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr));

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] m_size[NW], m_base[NW], m_remap[NW];
  logic [7:0]  m_attr[NW];
  logic [3:0]  m_tgt[NW];
  logic        m_en[NW];

  function automatic exp_t predict(logic [31:0] a, string tag);
    exp_t e;
    e.hit = 0; e.win = 0; e.tgt = 0; e.attr = 0; e.addr = 0; e.tag = tag;
    for (int i = 0; i < NW; i++) begin
      if (!e.hit && m_en[i] && ((a[31:16] & ~m_size[i]) == m_base[i])) begin
        e.hit = 1; e.win = 3'(i); e.tgt = m_tgt[i]; e.attr = m_attr[i];
        if (m_remap[i] != 0)
          e.addr = {(a[31:16] & m_size[i]) | (m_remap[i] & ~m_size[i]), a[15:0]};
        else
          e.addr = a;
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string what, string got, string want);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", what, got, want);
    end
  endtask

  // One clock slot: optional write and optional lookup; lookup sees pre-write state.
  task automatic step(bit w, int win, int sel, logic [31:0] d, bit r, logic [31:0] a, string tag);
    cfg_we = w; cfg_win = 3'(win); cfg_sel = 2'(sel); cfg_wdata = d;
    req_valid = r; req_addr = a;
    if (r) exp_q.push_back(predict(a, tag));
    if (w && win < NW) begin
      case (sel)
        0: begin m_size[win] = d[31:16]; m_attr[win] = d[15:8]; m_tgt[win] = d[7:4]; m_en[win] = d[0]; end
        1: m_base[win] = d[31:16];
        2: m_remap[win] = d[31:16];
        default: ;
      endcase
    end
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(int win, int sel, logic [31:0] d);
    step(1, win, sel, d, 0, 0, "");
  endtask

  task automatic look(logic [31:0] a, string tag);
    step(0, 0, 0, 0, 1, a, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected response", $sformatf("%h", rsp_addr), "none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_hit == e.hit && rsp_miss == !e.hit && rsp_win == e.win &&
              rsp_target == e.tgt && rsp_attr == e.attr && rsp_addr == e.addr,
              e.tag,
              $sformatf("hit=%0b miss=%0b win=%0d tgt=%h attr=%h addr=%h",
                        rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr, rsp_addr),
              $sformatf("hit=%0b miss=%0b win=%0d tgt=%h attr=%h addr=%h",
                        e.hit, !e.hit, e.win, e.tgt, e.attr, e.addr));
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_size[i] = 0; m_base[i] = 0; m_remap[i] = 0; m_attr[i] = 0; m_tgt[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && !rsp_hit && !rsp_miss, "R1 reset outputs",
          $sformatf("v=%0b h=%0b m=%0b", rsp_valid, rsp_hit, rsp_miss), "v=0 h=0 m=0");

    look(32'h1234_5678, "R1 lookup after reset misses");
    look(32'h0000_0000, "R1 R9 zero address misses");

    // Window 2: 1 MB at 0x4000_0000, attr A5, target 3; base written with low junk.
    wr(2, 0, 32'h000F_A53F);
    wr(2, 1, 32'h4000_1234);
    look(32'h400A_BCDE, "R3 R4 R5 hit window 2");
    look(32'h4010_0000, "R5 just past window 2 misses");
    look(32'h3FFF_FFFF, "R5 just below window 2 misses");

    wr(2, 2, 32'h8000_0000);
    look(32'h400A_BCDE, "R8 remap nonzero");
    wr(2, 2, 32'h8005_0000);
    look(32'h400A_BCDE, "R8 remap bits inside mask ignored");

    // Window 1: 16 MB overlapping window 2.
    wr(1, 1, 32'h4000_0000);
    wr(1, 0, 32'h00FF_1151);
    look(32'h400A_BCDE, "R7 lowest index wins overlap");
    look(32'h40F0_0004, "R7 only window 1 covers");

    wr(1, 0, 32'h00FF_1150);
    look(32'h400A_BCDE, "R6 disabled window 1 skipped");
    look(32'h40F0_0004, "R6 disabled window never matches");

    // Ignored writes: select code 3 and index out of range.
    wr(0, 3, 32'hFFFF_FFFF);
    wr(6, 0, 32'hFFFF_FFF1);
    wr(7, 0, 32'hFFFF_FFF1);
    look(32'h9000_0000, "R10 ignored writes leave all else missing");

    // Last window and same-cycle write/lookup.
    wr(5, 1, 32'hA000_0000);
    step(1, 5, 0, 32'h0000_7C91, 1, 32'hA000_1111, "R10 same-cycle write not seen");
    look(32'hA000_1111, "R10 write seen next cycle");
    look(32'hA001_0000, "R3 64KB window boundary miss");

    // Back-to-back lookups with remap zero again.
    wr(2, 2, 32'h0000_FFFF);
    look(32'h4001_0002, "R8 remap low bits dropped -> passthrough");
    look(32'hA000_FFFF, "R2 back-to-back 1");
    look(32'h5000_0000, "R2 back-to-back 2 miss");
    look(32'h400F_FFFF, "R5 top of window 2");

    step(0, 0, 0, 0, 0, 0, "");
    check(!rsp_valid && !rsp_hit && !rsp_miss, "R2 idle slot gives no response",
          $sformatf("v=%0b", rsp_valid), "v=0");
    check(exp_q.size() == 0, "R2 all responses arrived",
          $sformatf("%0d pending", exp_q.size()), "0 pending");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule